// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller services a cache miss by refilling one multi-word line from memory. When a miss is accepted it issues one burst request to memory that names the line and the word that missed. Memory returns the missed word on the first beat. It then returns the words that follow it, and finally the words at the start of the line. The controller passes the first beat straight to the CPU response port, so the processor can restart while the rest of the line is still arriving. Every beat, including the first, is written through the cache write port, and a per-word valid mask records which words are already present.

While the line is filling, the CPU may read words of that same line. A word that has already landed is returned at once. A word that has not yet arrived produces a wait indication, and the CPU repeats the access later. The controller refills one line at a time. A new miss is refused until the last word of the current line has been written.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req_valid`, `wr_en`, `cpu_rsp_valid`, `line_done` and all bits of `fill_valid` are 0.
- R2: A miss is accepted in a cycle where `miss_valid` and `miss_ready` are both 1. From the next cycle, `mem_req_valid` is 1, with `mem_req_line`/`mem_req_off` equal to the accepted line and word offset. These stay stable until a cycle in which `mem_req_ready` is 1, and `mem_req_valid` is 0 in the cycle after that one.
- R3: Beat i (counting from 0) of a refill is written one cycle after it arrives: `wr_en`=1, `wr_off` = (start offset + i) mod 8, and `wr_data` = beat data.
- R4: `cpu_rsp_valid` pulses for exactly one cycle, in the cycle the first beat is written, with `cpu_rsp_data` equal to that beat. No response is given for later beats.
- R5: Bit k of `fill_valid` becomes 1 in the same cycle that word k is written. The whole mask reads 0 in the cycle after a miss is accepted.
- R6: `line_done` pulses in the cycle that the eighth beat is written, and at that point `fill_valid` is all ones.
- R7: `miss_ready` is 0 from the cycle after acceptance until the cycle in which `line_done` is 1. A miss offered while `miss_ready` is 0 changes neither the requested line nor the offset.
- R8: An access (`acc_req`) to the line held by the controller, at a word whose `fill_valid` bit is 1, returns `acc_hit`=1 in the next cycle with `acc_data` equal to that word. This also applies after the refill has finished.
- R9: During a refill, an access to the held line at a word not yet valid returns `acc_wait`=1 and `acc_hit`=0 in the next cycle. An access to any other line returns neither.
- R10: A beat that arrives while the controller is idle, or before the burst request has been accepted by memory, is ignored: no write and no change to `fill_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset that missed |
| miss_ready | output | 1 | Controller idle; a miss can be accepted |
| mem_req_valid | output | 1 | Burst request to memory pending |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_req_line | output | LINE_W | Line to fetch |
| mem_req_off | output | OFF_W | First word of the wrapping burst |
| mem_beat_valid | input | 1 | A data beat is present |
| mem_beat_data | input | DATA_W | Beat data |
| cpu_rsp_valid | output | 1 | Early response carrying the missed word |
| cpu_rsp_data | output | DATA_W | Missed word |
| wr_en | output | 1 | Cache line word write strobe |
| wr_off | output | OFF_W | Word offset being written |
| wr_data | output | DATA_W | Word being written |
| fill_valid | output | WORDS | Per-word valid mask of the held line |
| line_done | output | 1 | Last word of the line written |
| acc_req | input | 1 | CPU access probe |
| acc_line | input | LINE_W | Line of the access |
| acc_off | input | OFF_W | Word of the access |
| acc_hit | output | 1 | Word served (one cycle after probe) |
| acc_wait | output | 1 | Word not yet filled; retry |
| acc_data | output | DATA_W | Served word |

## Verification
The wrap counter or its base could drift. That fault would show within one cycle of the next beat, as a `wr_off` outside the expected (start + i) mod 8 order and a `fill_valid` bit set in the wrong place. A state machine that leaves the wait-for-first-beat state at the wrong time shows up in the same write cycle. The early response would then be missing or duplicated, or `line_done` and `miss_ready` would reach the idle boundary a beat early or late. A corrupted valid mask would not show at the write port. It would show on the next probe of the held line, as a hit where a wait is due or a wait where a hit is due.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_FILL  = 2'd2
  } cwf_state_e;
endpackage

// File: rtl/cwf_wrap_seq.sv
module cwf_wrap_seq #(
  parameter int WORDS = 8,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] load_off,
  input  logic             step,
  output logic [OFF_W-1:0] cur_off,
  output logic             is_last
);
  localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(WORDS - 1);
  localparam bit POW2 = ((WORDS & (WORDS - 1)) == 0);

  logic [OFF_W-1:0] base_q;
  logic [OFF_W-1:0] cnt_q;

  assign is_last = (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_off;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q <= is_last ? '0 : cnt_q + 1'b1;
    end
  end

  generate
    if (POW2) begin : g_pow2
      assign cur_off = base_q + cnt_q;
    end else begin : g_mod
      logic [OFF_W:0] sum;
      assign sum     = {1'b0, base_q} + {1'b0, cnt_q};
      assign cur_off = (sum >= (OFF_W+1)'(WORDS)) ? OFF_W'(sum - (OFF_W+1)'(WORDS))
                                                  : sum[OFF_W-1:0];
    end
  endgenerate

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> (cnt_q == ($past(is_last) ? '0 : $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/cwf_valid_track.sv
module cwf_valid_track #(
  parameter int WORDS = 8,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set,
  input  logic [OFF_W-1:0] set_idx,
  output logic [WORDS-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask <= '0;
    end else if (set) begin
      mask[set_idx] <= 1'b1;
    end
  end

  // R5
  mask_grow_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ($countones(mask) >= $countones($past(mask))));
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [OFF_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
  import cwf_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [OFF_W-1:0]  miss_off,
  output logic              miss_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [OFF_W-1:0]  mem_req_off,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              wr_en,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data,
  output logic [WORDS-1:0]  fill_valid,
  output logic              line_done,
  input  logic              acc_req,
  input  logic [LINE_W-1:0] acc_line,
  input  logic [OFF_W-1:0]  acc_off,
  output logic              acc_hit,
  output logic              acc_wait,
  output logic [DATA_W-1:0] acc_data
);
  cwf_state_e        state_q;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  off_q;
  logic              req_q;
  logic              held_q;
  logic              accept;
  logic              beat_ok;
  logic [OFF_W-1:0]  cur_off;
  logic              is_last;
  logic              acc_match;

  assign miss_ready    = (state_q == ST_IDLE);
  assign accept        = miss_valid && miss_ready;
  assign beat_ok       = mem_beat_valid && (state_q != ST_IDLE) && !req_q;
  assign mem_req_valid = req_q;
  assign mem_req_line  = line_q;
  assign mem_req_off   = off_q;
  assign acc_match     = acc_req && held_q && (acc_line == line_q);

  cwf_wrap_seq #(.WORDS(WORDS), .OFF_W(OFF_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_off (miss_off),
    .step     (beat_ok),
    .cur_off  (cur_off),
    .is_last  (is_last)
  );

  cwf_valid_track #(.WORDS(WORDS), .OFF_W(OFF_W)) u_valid (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .set     (beat_ok),
    .set_idx (cur_off),
    .mask    (fill_valid)
  );

  cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk   (clk),
    .we    (beat_ok),
    .waddr (cur_off),
    .wdata (mem_beat_data),
    .raddr (acc_off),
    .rdata (acc_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      line_q        <= '0;
      off_q         <= '0;
      req_q         <= 1'b0;
      held_q        <= 1'b0;
      wr_en         <= 1'b0;
      wr_off        <= '0;
      wr_data       <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_data  <= '0;
      line_done     <= 1'b0;
      acc_hit       <= 1'b0;
      acc_wait      <= 1'b0;
    end else begin
      wr_en         <= beat_ok;
      wr_off        <= cur_off;
      wr_data       <= mem_beat_data;
      cpu_rsp_valid <= beat_ok && (state_q == ST_WAIT1);
      if (beat_ok && (state_q == ST_WAIT1)) cpu_rsp_data <= mem_beat_data;
      line_done     <= beat_ok && is_last;
      acc_hit       <= acc_match && fill_valid[acc_off];
      acc_wait      <= acc_match && !fill_valid[acc_off] && (state_q != ST_IDLE);
      if (req_q && mem_req_ready) req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_WAIT1;
            req_q   <= 1'b1;
            held_q  <= 1'b1;
            line_q  <= miss_line;
            off_q   <= miss_off;
          end
        end
        ST_WAIT1: begin
          if (beat_ok) state_q <= is_last ? ST_IDLE : ST_FILL;
        end
        ST_FILL: begin
          if (beat_ok && is_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_off) && $stable(mem_req_line));

  // R3
  wrap_order_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !line_done |=> !wr_en ||
      (wr_off == (($past(wr_off) == OFF_W'(WORDS - 1)) ? '0 : $past(wr_off) + 1'b1)));

  // R4
  early_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> wr_en && (wr_off == mem_req_off) && (cpu_rsp_data == wr_data));

  // R5
  valid_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> fill_valid[wr_off]);

  // R6
  done_full_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (&fill_valid) && miss_ready);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    miss_valid && !miss_ready |=> $stable(mem_req_line) && $stable(mem_req_off));
endmodule

// File: tb/cwf_refill_ctrl_bench.sv
module cwf_refill_ctrl_bench;
  localparam int LINE_W = 26;
  localparam int DATA_W = 32;
  localparam int WORDS  = 8;
  localparam int OFF_W  = 3;
  localparam int NV     = 6;
  // columns: line, start offset, request latency, gap between beats
  localparam int VT [NV][4] = '{
    '{32'h00123, 0, 0, 0},
    '{32'h0ABCD, 3, 2, 0},
    '{32'h3FFFF, 7, 0, 1},
    '{32'h00042, 5, 1, 2},
    '{32'h01234, 1, 3, 0},
    '{32'h2AAAA, 6, 0, 3}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              miss_valid;
  logic [LINE_W-1:0] miss_line;
  logic [OFF_W-1:0]  miss_off;
  logic              miss_ready;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [LINE_W-1:0] mem_req_line;
  logic [OFF_W-1:0]  mem_req_off;
  logic              mem_beat_valid;
  logic [DATA_W-1:0] mem_beat_data;
  logic              cpu_rsp_valid;
  logic [DATA_W-1:0] cpu_rsp_data;
  logic              wr_en;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] wr_data;
  logic [WORDS-1:0]  fill_valid;
  logic              line_done;
  logic              acc_req;
  logic [LINE_W-1:0] acc_line;
  logic [OFF_W-1:0]  acc_off;
  logic              acc_hit;
  logic              acc_wait;
  logic [DATA_W-1:0] acc_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cwf_refill_ctrl #(.LINE_W(LINE_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_cwf_refill_ctrl (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_off(miss_off), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_req_off(mem_req_off),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .fill_valid(fill_valid), .line_done(line_done),
    .acc_req(acc_req), .acc_line(acc_line), .acc_off(acc_off),
    .acc_hit(acc_hit), .acc_wait(acc_wait), .acc_data(acc_data)
  );

  function automatic logic [DATA_W-1:0] mkdata(input logic [LINE_W-1:0] ln, input int o);
    return (DATA_W'(ln) << 4) ^ DATA_W'(o) ^ 32'hA500_0000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_miss(input logic [LINE_W-1:0] ln, input int o);
    miss_valid = 1'b1; miss_line = ln; miss_off = OFF_W'(o);
    tick();
    miss_valid = 1'b0;
    chk("R2 req valid", 64'(mem_req_valid), 64'd1);
    chk("R2 req off", 64'(mem_req_off), 64'(o));
    chk("R2 req line", 64'(mem_req_line), 64'(ln));
    chk("R7 busy", 64'(miss_ready), 64'd0);
    chk("R5 cleared", 64'(fill_valid), 64'd0);
  endtask

  task automatic grant(input int lat);
    for (int k = 0; k < lat; k++) begin
      tick();
      chk("R2 req held", 64'(mem_req_valid), 64'd1);
    end
    mem_req_ready = 1'b1;
    tick();
    mem_req_ready = 1'b0;
    chk("R2 req dropped", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic send_beat(input logic [LINE_W-1:0] ln, input int so, input int i,
                           inout logic [WORDS-1:0] m);
    int eo;
    logic [DATA_W-1:0] d;
    eo = (so + i) % WORDS;
    d  = mkdata(ln, eo);
    mem_beat_valid = 1'b1; mem_beat_data = d;
    tick();
    mem_beat_valid = 1'b0;
    m[eo] = 1'b1;
    chk("R3 wr_en", 64'(wr_en), 64'd1);
    chk("R3 wr_off", 64'(wr_off), 64'(eo));
    chk("R3 wr_data", 64'(wr_data), 64'(d));
    chk("R4 rsp valid", 64'(cpu_rsp_valid), 64'(i == 0));
    if (i == 0) chk("R4 rsp data", 64'(cpu_rsp_data), 64'(d));
    chk("R5 mask", 64'(fill_valid), 64'(m));
    chk("R6 done", 64'(line_done), 64'(i == WORDS - 1));
    chk("R7 ready", 64'(miss_ready), 64'(i == WORDS - 1));
  endtask

  task automatic probe(input logic [LINE_W-1:0] ln, input int o);
    acc_req = 1'b1; acc_line = ln; acc_off = OFF_W'(o);
    tick();
    acc_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WORDS-1:0] m;
    logic [LINE_W-1:0] ln;
    rst = 1'b1; miss_valid = 1'b0; miss_line = '0; miss_off = '0;
    mem_req_ready = 1'b0; mem_beat_valid = 1'b0; mem_beat_data = '0;
    acc_req = 1'b0; acc_line = '0; acc_off = '0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 miss_ready", 64'(miss_ready), 64'd1);
    chk("R1 req", 64'(mem_req_valid), 64'd0);
    chk("R1 wr_en", 64'(wr_en), 64'd0);
    chk("R1 rsp", 64'(cpu_rsp_valid), 64'd0);
    chk("R1 done", 64'(line_done), 64'd0);
    chk("R1 mask", 64'(fill_valid), 64'd0);

    // R10 beat while idle is ignored
    mem_beat_valid = 1'b1; mem_beat_data = 32'hDEAD_BEEF;
    tick();
    mem_beat_valid = 1'b0;
    chk("R10 idle beat wr", 64'(wr_en), 64'd0);
    chk("R10 idle beat mask", 64'(fill_valid), 64'd0);

    // table of refills
    for (int v = 0; v < NV; v++) begin
      ln = LINE_W'(VT[v][0]);
      m  = '0;
      start_miss(ln, VT[v][1]);
      grant(VT[v][2]);
      for (int i = 0; i < WORDS; i++) begin
        send_beat(ln, VT[v][1], i, m);
        for (int g = 0; g < VT[v][3]; g++) begin
          tick();
          chk("R3 no write in gap", 64'(wr_en), 64'd0);
        end
      end
    end

    // directed: mid-fill probes, busy miss, early beat
    ln = 26'h0155;
    m  = '0;
    start_miss(ln, 5);
    mem_beat_valid = 1'b1; mem_beat_data = 32'h1111_2222;
    tick();
    mem_beat_valid = 1'b0;
    chk("R10 early beat wr", 64'(wr_en), 64'd0);
    chk("R10 early beat mask", 64'(fill_valid), 64'd0);
    grant(0);
    for (int i = 0; i < 3; i++) send_beat(ln, 5, i, m);
    probe(ln, 6);
    chk("R8 hit", 64'(acc_hit), 64'd1);
    chk("R8 data", 64'(acc_data), 64'(mkdata(ln, 6)));
    chk("R8 no wait", 64'(acc_wait), 64'd0);
    probe(ln, 1);
    chk("R9 wait", 64'(acc_wait), 64'd1);
    chk("R9 no hit", 64'(acc_hit), 64'd0);
    probe(26'h02AA, 5);
    chk("R9 other line hit", 64'(acc_hit), 64'd0);
    chk("R9 other line wait", 64'(acc_wait), 64'd0);
    miss_valid = 1'b1; miss_line = 26'h02AA; miss_off = 3'd0;
    tick();
    miss_valid = 1'b0;
    chk("R7 busy ready", 64'(miss_ready), 64'd0);
    chk("R7 line kept", 64'(mem_req_line), 64'(ln));
    chk("R7 off kept", 64'(mem_req_off), 64'd5);
    chk("R7 no new req", 64'(mem_req_valid), 64'd0);
    for (int i = 3; i < WORDS; i++) send_beat(ln, 5, i, m);
    probe(ln, 1);
    chk("R8 hit after done", 64'(acc_hit), 64'd1);
    chk("R8 data after done", 64'(acc_data), 64'(mkdata(ln, 1)));
    chk("R8 no wait after done", 64'(acc_wait), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule